// File: doc/BRIEF.md
# Dual-Direction Width-Converting FIFO Pair

The block joins one 36-bit word port to two 18-bit lanes through two independent first-in first-out buffers. The outbound buffer is filled with whole words from the wide side. A transmit lane drains it piece by piece. The inbound buffer is filled piece by piece from a receive lane and is read as whole words on the wide side. Each of the three sides has its own clock and enables. Every buffer pointer that crosses between clocks passes through Gray-coded synchronizer chains.

Each narrow lane moves a word either as two 18-bit halves or as four 9-bit quarters. The lane order is selectable: the most significant piece first (big order) or the least significant piece first (little order). Both settings are taken from the configuration pins only while reset is held. Reset also clears every pointer and any word that is half sent or half built. Both read sides are show-ahead: the current piece or word is on the data pins whenever the matching empty flag is low, and an enabled read moves past it.

Top module: `bmf_top`

## Requirements
- R1: Words written on the wide port leave the transmit lane in the order they were written, and words assembled from the receive lane reach the wide read port in the order they were completed.
- R2: In half mode (cfg_quarter=0), each outbound word leaves as two pieces on t_data. Big order (cfg_little=0) sends bits [35:18] first. Little order sends bits [17:0] first.
- R3: In quarter mode (cfg_quarter=1), each outbound word leaves as four 9-bit pieces on t_data[8:0], with t_data[17:9] at zero. Big order sends bits [35:27] first and then the lower quarters in turn. Little order starts with bits [8:0] and works upward. A word is released from the buffer only after its last piece is read.
- R4: In half mode, two accepted writes on r_data form one inbound word. With big order the first piece lands in bits [35:18]; with little order it lands in bits [17:0].
- R5: In quarter mode, four accepted writes form one inbound word, using only r_data[8:0]. With big order the first piece lands in bits [35:27]; with little order it lands in bits [8:0]. The word enters the buffer only when its fourth piece is accepted.
- R6: Right after reset, t_empty and w_empty are 1 and w_full and r_full are 0.
- R7: w_full is 1 once DEPTH words are stored in the outbound buffer. A wide write while w_full is 1 is ignored, so no extra word ever leaves the transmit lane.
- R8: r_full is 1 once DEPTH whole words are stored in the inbound buffer. A receive write while r_full is 1 is ignored, including its effect on the word being built.
- R9: A transmit read while t_empty is 1 and a wide read while w_empty is 1 are ignored. The next word still starts with its first piece.
- R10: cfg_quarter and cfg_little are taken only while rst_n is 0. Changing them afterwards has no effect on either lane.
- R11: Reset discards a partly read outbound word and a partly built inbound word. The next traffic starts at piece zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Wide-side clock |
| t_clk | input | 1 | Transmit-lane clock |
| r_clk | input | 1 | Receive-lane clock |
| rst_n | input | 1 | Asynchronous active-low reset for all sides; configuration is sampled while low |
| cfg_quarter | input | 1 | 1 = 9-bit pieces, 0 = 18-bit pieces |
| cfg_little | input | 1 | 1 = least significant piece first, 0 = most significant first |
| w_wr_en | input | 1 | Write enable into the outbound buffer |
| w_wr_data | input | 36 | Outbound word |
| w_full | output | 1 | Outbound buffer full |
| w_rd_en | input | 1 | Read enable from the inbound buffer |
| w_rd_data | output | 36 | Inbound word (show-ahead) |
| w_empty | output | 1 | Inbound buffer empty |
| t_rd_en | input | 1 | Takes the current transmit piece |
| t_data | output | 18 | Current transmit piece |
| t_empty | output | 1 | No outbound word available |
| r_wr_en | input | 1 | Writes one receive piece |
| r_data | input | 18 | Receive piece |
| r_full | output | 1 | Inbound buffer full |

## Verification
Each of the four unit/order combinations is run in both directions with word values whose pieces all differ. A swapped, repeated or shifted piece therefore shows up as a mismatch. In quarter mode the receive lane carries changing junk in its upper nine bits, which separates a correct packer from one that reads the wrong bits. The configuration pins are inverted right after every reset, so a design that follows them live gives the wrong piece order. Fill-to-capacity runs with one extra word, reads while empty, and resets in the middle of a word separate correct flag and reset handling from off-by-one pointers and leftover partial state.

// File: rtl/bmf_pkg.sv
`timescale 1ns/1ps
package bmf_pkg;

   typedef enum logic {
      UNIT_HALF    = 1'b0,
      UNIT_QUARTER = 1'b1
   } lane_unit_e;

   typedef enum logic {
      ORD_BIG    = 1'b0,
      ORD_LITTLE = 1'b1
   } lane_order_e;

   typedef struct packed {
      lane_unit_e  unit;
      lane_order_e order;
   } lane_cfg_t;

   // Position (counted from the least significant end) of the piece
   // that travels as number idx out of cnt pieces.
   function automatic int lane_slot(input int idx, input int cnt, input logic little);
      return little ? idx : (cnt - 1 - idx);
   endfunction

endpackage

// File: rtl/bmf_gray_sync.sv
`timescale 1ns/1ps
module bmf_gray_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bmf_async_fifo.sv
`timescale 1ns/1ps
module bmf_async_fifo #(
   parameter int DW     = 36,
   parameter int DEPTH  = 16,
   parameter int SYNC   = 2,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          wr_full,
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_empty
);

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   logic [DW-1:0] store [DEPTH];
   logic [PW-1:0] wbin, wgray, wbin_nx;
   logic [PW-1:0] rbin, rgray, rbin_nx;
   logic [PW-1:0] wgray_at_rd, rgray_at_wr;
   logic          do_push, do_pop;

   assign do_push = wr_en && !wr_full;
   assign do_pop  = rd_en && !rd_empty;
   assign wbin_nx = wbin + 1'b1;
   assign rbin_nx = rbin + 1'b1;

   // write domain
   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (do_push) begin
         wbin  <= wbin_nx;
         wgray <= to_gray(wbin_nx);
      end
   end

   always_ff @(posedge wr_clk) begin
      if (do_push) store[wbin[AW-1:0]] <= wr_data;
   end

   // read domain
   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (do_pop) begin
         rbin  <= rbin_nx;
         rgray <= to_gray(rbin_nx);
      end
   end

   assign rd_data = store[rbin[AW-1:0]];

   // pointer crossings
   bmf_gray_sync #(.W(PW), .STAGES(SYNC)) u_w2r (
      .clk   (rd_clk),
      .rst_n (rd_rst_n),
      .d     (wgray),
      .q     (wgray_at_rd)
   );

   bmf_gray_sync #(.W(PW), .STAGES(SYNC)) u_r2w (
      .clk   (wr_clk),
      .rst_n (wr_rst_n),
      .d     (rgray),
      .q     (rgray_at_wr)
   );

   assign rd_empty = (rgray == wgray_at_rd);
   assign wr_full  = (wgray == {~rgray_at_wr[PW-1:PW-2], rgray_at_wr[PW-3:0]});

endmodule

// File: rtl/bmf_unpack.sv
`timescale 1ns/1ps
module bmf_unpack
   import bmf_pkg::*;
#(
   parameter int WIDE   = 36,
   parameter int NARROW = 18,
   parameter int UNIT   = 9,
   localparam int QN    = WIDE / UNIT,
   localparam int HN    = WIDE / NARROW,
   localparam int IW    = $clog2(QN),
   localparam int HW    = $clog2(HN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_cfg_t         cfg,
   input  logic [WIDE-1:0]   word,
   input  logic              word_ok,
   input  logic              rd_en,
   output logic [NARROW-1:0] data,
   output logic              pop,
   output logic [IW-1:0]     part_idx
);

   logic [UNIT-1:0]   qpart [QN];
   logic [NARROW-1:0] hpart [HN];
   logic [IW-1:0]     idx_q, last_idx, slot;
   logic              take;

   for (genvar g = 0; g < QN; g++) begin : g_qpart
      assign qpart[g] = word[g*UNIT +: UNIT];
   end

   for (genvar g = 0; g < HN; g++) begin : g_hpart
      assign hpart[g] = word[g*NARROW +: NARROW];
   end

   always_comb begin
      last_idx = (cfg.unit == UNIT_QUARTER) ? IW'(QN - 1) : IW'(HN - 1);
      slot     = IW'(lane_slot(int'(idx_q), int'(last_idx) + 1, cfg.order == ORD_LITTLE));
      if (cfg.unit == UNIT_QUARTER) data = NARROW'(qpart[slot]);
      else                          data = hpart[slot[HW-1:0]];
   end

   assign take     = rd_en && word_ok;
   assign pop      = take && (idx_q == last_idx);
   assign part_idx = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idx_q <= '0;
      else if (take && pop)        idx_q <= '0;
      else if (take)               idx_q <= idx_q + 1'b1;
   end

endmodule

// File: rtl/bmf_pack.sv
`timescale 1ns/1ps
module bmf_pack
   import bmf_pkg::*;
#(
   parameter int WIDE   = 36,
   parameter int NARROW = 18,
   parameter int UNIT   = 9,
   localparam int QN    = WIDE / UNIT,
   localparam int HN    = WIDE / NARROW,
   localparam int IW    = $clog2(QN),
   localparam int HW    = $clog2(HN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_cfg_t         cfg,
   input  logic [NARROW-1:0] din,
   input  logic              wr_en,
   input  logic              fifo_full,
   output logic              push,
   output logic [WIDE-1:0]   word,
   output logic [IW-1:0]     part_idx
);

   logic [WIDE-1:0] acc_q, acc_nx;
   logic [IW-1:0]   idx_q, last_idx, slot;
   logic            accept;

   assign accept = wr_en && !fifo_full;

   always_comb begin
      last_idx = (cfg.unit == UNIT_QUARTER) ? IW'(QN - 1) : IW'(HN - 1);
      slot     = IW'(lane_slot(int'(idx_q), int'(last_idx) + 1, cfg.order == ORD_LITTLE));
      acc_nx   = acc_q;
      if (cfg.unit == UNIT_QUARTER) acc_nx[int'(slot)*UNIT +: UNIT] = din[UNIT-1:0];
      else                          acc_nx[int'(slot[HW-1:0])*NARROW +: NARROW] = din;
   end

   assign push     = accept && (idx_q == last_idx);
   assign word     = acc_nx;
   assign part_idx = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         idx_q <= '0;
      end else if (accept) begin
         acc_q <= acc_nx;
         idx_q <= push ? '0 : idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/bmf_top.sv
`timescale 1ns/1ps
module bmf_top
   import bmf_pkg::*;
#(
   parameter int WIDE        = 36,
   parameter int NARROW      = 18,
   parameter int UNIT        = 9,
   parameter int DEPTH       = 2048,
   parameter int SYNC_STAGES = 2
) (
   input  logic              w_clk,
   input  logic              t_clk,
   input  logic              r_clk,
   input  logic              rst_n,
   input  logic              cfg_quarter,
   input  logic              cfg_little,
   input  logic              w_wr_en,
   input  logic [WIDE-1:0]   w_wr_data,
   output logic              w_full,
   input  logic              w_rd_en,
   output logic [WIDE-1:0]   w_rd_data,
   output logic              w_empty,
   input  logic              t_rd_en,
   output logic [NARROW-1:0] t_data,
   output logic              t_empty,
   input  logic              r_wr_en,
   input  logic [NARROW-1:0] r_data,
   output logic              r_full
);

   localparam int PIDX_W = $clog2(WIDE / UNIT);

   // elaboration checks
   if (WIDE != 2 * NARROW || NARROW != 2 * UNIT) begin : g_bad_geometry
      $error("bmf_top: WIDE must be 2*NARROW and NARROW must be 2*UNIT");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bmf_top: DEPTH must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bmf_top: SYNC_STAGES must be at least 2");
   end

   lane_cfg_t cfg_in, cfg_t_q, cfg_r_q;

   assign cfg_in.unit  = cfg_quarter ? UNIT_QUARTER : UNIT_HALF;
   assign cfg_in.order = cfg_little  ? ORD_LITTLE   : ORD_BIG;

   // configuration is captured only while reset is held
   always_ff @(posedge t_clk) begin
      if (!rst_n) cfg_t_q <= cfg_in;
   end

   always_ff @(posedge r_clk) begin
      if (!rst_n) cfg_r_q <= cfg_in;
   end

   // outbound: wide writer -> transmit lane
   logic [WIDE-1:0]   ob_word;
   logic              ob_empty, ob_pop;
   logic [PIDX_W-1:0] tx_idx;

   bmf_async_fifo #(.DW(WIDE), .DEPTH(DEPTH), .SYNC(SYNC_STAGES)) u_ob (
      .wr_clk   (w_clk),
      .wr_rst_n (rst_n),
      .wr_en    (w_wr_en),
      .wr_data  (w_wr_data),
      .wr_full  (w_full),
      .rd_clk   (t_clk),
      .rd_rst_n (rst_n),
      .rd_en    (ob_pop),
      .rd_data  (ob_word),
      .rd_empty (ob_empty)
   );

   bmf_unpack #(.WIDE(WIDE), .NARROW(NARROW), .UNIT(UNIT)) u_unpack (
      .clk      (t_clk),
      .rst_n    (rst_n),
      .cfg      (cfg_t_q),
      .word     (ob_word),
      .word_ok  (!ob_empty),
      .rd_en    (t_rd_en),
      .data     (t_data),
      .pop      (ob_pop),
      .part_idx (tx_idx)
   );

   assign t_empty = ob_empty;

   // inbound: receive lane -> wide reader
   logic [WIDE-1:0]   ib_word;
   logic              ib_full, ib_push;
   logic [PIDX_W-1:0] rx_idx;

   bmf_pack #(.WIDE(WIDE), .NARROW(NARROW), .UNIT(UNIT)) u_pack (
      .clk       (r_clk),
      .rst_n     (rst_n),
      .cfg       (cfg_r_q),
      .din       (r_data),
      .wr_en     (r_wr_en),
      .fifo_full (ib_full),
      .push      (ib_push),
      .word      (ib_word),
      .part_idx  (rx_idx)
   );

   bmf_async_fifo #(.DW(WIDE), .DEPTH(DEPTH), .SYNC(SYNC_STAGES)) u_ib (
      .wr_clk   (r_clk),
      .wr_rst_n (rst_n),
      .wr_en    (ib_push),
      .wr_data  (ib_word),
      .wr_full  (ib_full),
      .rd_clk   (w_clk),
      .rd_rst_n (rst_n),
      .rd_en    (w_rd_en),
      .rd_data  (w_rd_data),
      .rd_empty (w_empty)
   );

   assign r_full = ib_full;

endmodule

// File: rtl/bmf_top_chk.sv
`timescale 1ns/1ps
module bmf_top_chk #(
   parameter int NARROW = 18,
   parameter int UNIT   = 9,
   parameter int IW     = 2
) (
   input logic              t_clk,
   input logic              r_clk,
   input logic              rst_n,
   input logic              w_full,
   input logic              w_empty,
   input logic              t_empty,
   input logic              r_full,
   input logic              t_rd_en,
   input logic              r_wr_en,
   input logic [NARROW-1:0] t_data,
   input logic              quarter_t,
   input logic              little_t,
   input logic              quarter_r,
   input logic [IW-1:0]     tx_idx,
   input logic [IW-1:0]     rx_idx
);

   // R6
   reset_flags_chk: assert property (@(posedge t_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (t_empty && w_empty && !w_full && !r_full));

   // R11
   reset_idx_clear_chk: assert property (@(posedge t_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (tx_idx == '0 && rx_idx == '0));

   // R3
   quarter_upper_zero_chk: assert property (@(posedge t_clk) disable iff (!rst_n)
      (quarter_t && !t_empty) |-> (t_data[NARROW-1:UNIT] == '0));

   // R2
   half_idx_range_chk: assert property (@(posedge t_clk) disable iff (!rst_n)
      !quarter_t |-> (tx_idx < IW'(2)));

   // R9
   empty_read_hold_chk: assert property (@(posedge t_clk) disable iff (!rst_n)
      (t_empty && t_rd_en) |=> $stable(tx_idx));

   // R8
   full_write_hold_chk: assert property (@(posedge r_clk) disable iff (!rst_n)
      (r_full && r_wr_en) |=> $stable(rx_idx));

   // R10
   cfg_frozen_tx_chk: assert property (@(posedge t_clk) disable iff (!rst_n)
      1'b1 |=> ($stable(quarter_t) && $stable(little_t)));

   // R10
   cfg_frozen_rx_chk: assert property (@(posedge r_clk) disable iff (!rst_n)
      1'b1 |=> $stable(quarter_r));

endmodule

bind bmf_top bmf_top_chk #(.NARROW(NARROW), .UNIT(UNIT), .IW(PIDX_W)) u_chk (
   .t_clk     (t_clk),
   .r_clk     (r_clk),
   .rst_n     (rst_n),
   .w_full    (w_full),
   .w_empty   (w_empty),
   .t_empty   (t_empty),
   .r_full    (r_full),
   .t_rd_en   (t_rd_en),
   .r_wr_en   (r_wr_en),
   .t_data    (t_data),
   .quarter_t (cfg_t_q.unit),
   .little_t  (cfg_t_q.order),
   .quarter_r (cfg_r_q.unit),
   .tx_idx    (tx_idx),
   .rx_idx    (rx_idx)
);

// File: tb/bmf_top_bench.sv
`timescale 1ns/1ps
module bmf_top_bench;

   localparam int DEPTH = 8;

   logic        clk, rst_n, cfg_quarter, cfg_little;
   logic        w_wr_en, w_full, w_rd_en, w_empty;
   logic [35:0] w_wr_data, w_rd_data;
   logic        t_rd_en, t_empty, r_wr_en, r_full;
   logic [17:0] t_data, r_data;

   bmf_top #(.DEPTH(DEPTH)) u_bmf_top (
      .w_clk (clk), .t_clk (clk), .r_clk (clk), .rst_n (rst_n),
      .cfg_quarter (cfg_quarter), .cfg_little (cfg_little),
      .w_wr_en (w_wr_en), .w_wr_data (w_wr_data), .w_full (w_full),
      .w_rd_en (w_rd_en), .w_rd_data (w_rd_data), .w_empty (w_empty),
      .t_rd_en (t_rd_en), .t_data (t_data), .t_empty (t_empty),
      .r_wr_en (r_wr_en), .r_data (r_data), .r_full (r_full)
   );

   int          n_cmp = 0;
   int          n_bad = 0;
   logic [35:0] q_out [$];
   logic [35:0] q_in  [$];
   bit          tx_on = 0, wr_on = 0;
   bit          eq = 0, el = 0;
   int          tidx = 0;

   initial begin
      clk = 0;
      forever #10 clk = ~clk;
   end

   function automatic logic [17:0] part_of(input logic [35:0] w, input int k,
                                           input bit q, input bit l);
      int cnt, s;
      cnt = q ? 4 : 2;
      s   = l ? k : cnt - 1 - k;
      if (q) return {9'b0, w[s*9 +: 9]};
      return w[s*18 +: 18];
   endfunction

   function automatic logic [35:0] pat(input int i, input int c);
      logic [35:0] v;
      v = 36'h1_2345_6789 * 36'(i + 1) ^ (36'h9_A5C3_0F1E << c);
      return v;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [35:0] act, input logic [35:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic tick;
      @(negedge clk);
      #1;
   endtask

   // transmit-lane monitor: takes pieces and compares with the scoreboard
   initial begin
      t_rd_en = 0;
      forever begin
         logic [17:0] exp;
         @(negedge clk);
         if (rst_n && tx_on) begin
            if (!t_empty) begin
               if (q_out.size() == 0) begin
                  check(0, "R7 (unexpected outbound word)", 36'(t_data), 36'h0);
                  t_rd_en = 0;
               end else begin
                  exp = part_of(q_out[0], tidx, eq, el);
                  check(t_data == exp, eq ? "R1/R3" : "R1/R2", 36'(t_data), 36'(exp));
                  t_rd_en = 1;
                  if (tidx == (eq ? 3 : 1)) begin
                     tidx = 0;
                     void'(q_out.pop_front());
                  end else tidx++;
               end
            end else t_rd_en = 0;
         end
      end
   end

   // wide-side monitor for the inbound direction
   initial begin
      w_rd_en = 0;
      forever begin
         @(negedge clk);
         if (rst_n && wr_on) begin
            if (!w_empty) begin
               if (q_in.size() == 0) begin
                  check(0, "R8 (unexpected inbound word)", w_rd_data, 36'h0);
                  w_rd_en = 0;
               end else begin
                  check(w_rd_data == q_in[0], eq ? "R1/R5" : "R1/R4", w_rd_data, q_in[0]);
                  void'(q_in.pop_front());
                  w_rd_en = 1;
               end
            end else w_rd_en = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(0, "watchdog", 36'h0, 36'h1);
      finish_run();
   end

   task automatic do_reset(input bit q, input bit l);
      tick;
      rst_n = 0; cfg_quarter = q; cfg_little = l; eq = q; el = l;
      tx_on = 0; wr_on = 0; t_rd_en = 0; w_rd_en = 0; w_wr_en = 0; r_wr_en = 0;
      q_out.delete(); q_in.delete(); tidx = 0;
      repeat (3) tick;
      rst_n = 1;
      tick;
      // R6
      check(t_empty && w_empty && !w_full && !r_full, "R6",
            36'({t_empty, w_empty, w_full, r_full}), 36'b1100);
   endtask

   task automatic wide_write(input logic [35:0] d, input bit ok);
      tick;
      check(w_full == !ok, "R7 (w_full)", 36'(w_full), 36'(!ok));
      w_wr_en = 1; w_wr_data = d;
      if (ok) q_out.push_back(d);
      tick;
      w_wr_en = 0;
   endtask

   task automatic rx_send(input logic [35:0] d, input bit ok);
      int cnt;
      logic [17:0] p;
      cnt = eq ? 4 : 2;
      tick;
      check(r_full == !ok, "R8 (r_full)", 36'(r_full), 36'(!ok));
      for (int k = 0; k < cnt; k++) begin
         p = part_of(d, k, eq, el);
         if (eq) p[17:9] = 9'h1A5 ^ 9'(k * 37);  // R5: junk in the unused bits
         r_data = p; r_wr_en = 1;
         if (k == cnt - 1 && ok) q_in.push_back(d);
         tick;
      end
      r_wr_en = 0;
   endtask

   task automatic drain;
      while (q_out.size() != 0 || q_in.size() != 0) tick;
      repeat (8) tick;
      check(t_empty && w_empty, "R1 (all drained)", 36'({t_empty, w_empty}), 36'b11);
   endtask

   initial begin
      rst_n = 0; cfg_quarter = 0; cfg_little = 0;
      w_wr_en = 0; w_wr_data = '0; r_wr_en = 0; r_data = '0;

      // all four unit/order combinations, configuration pins flipped after reset (R10)
      for (int c = 0; c < 4; c++) begin
         do_reset(c[1], c[0]);
         cfg_quarter = !c[1]; cfg_little = !c[0];
         tx_on = 1; wr_on = 1;
         for (int i = 0; i < 6; i++) begin
            wide_write(pat(i, c), 1);
            rx_send(~pat(i + 7, c), 1);
         end
         drain;
      end

      // R7: fill outbound buffer, extra word ignored
      do_reset(1, 0);
      for (int i = 0; i < DEPTH; i++) wide_write(pat(i, 5), 1);
      wide_write(36'hF_0F0F_0F0F, 0);
      tx_on = 1;
      drain;

      // R8: fill inbound buffer, extra word ignored
      do_reset(0, 1);
      for (int i = 0; i < DEPTH; i++) rx_send(pat(i, 9), 1);
      repeat (4) tick;
      rx_send(36'h3_3333_CCCC, 0);
      wr_on = 1;
      drain;

      // R9: reads while empty change nothing
      do_reset(1, 1);
      t_rd_en = 1; w_rd_en = 1;
      repeat (4) tick;
      t_rd_en = 0; w_rd_en = 0;
      check(t_empty && w_empty, "R9 (still empty)", 36'({t_empty, w_empty}), 36'b11);
      wide_write(36'hA_BCDE_F012, 1);
      rx_send(36'h1_1223_3445, 1);
      tx_on = 1; wr_on = 1;
      drain;

      // R11: reset in the middle of a word on both lanes
      do_reset(1, 0);
      wide_write(36'h5_6789_ABCD, 1);
      repeat (4) tick;
      check(!t_empty, "R11 (word present)", 36'(t_empty), 36'h0);
      check(t_data == part_of(36'h5_6789_ABCD, 0, 1, 0), "R3 (first quarter)",
            36'(t_data), 36'(part_of(36'h5_6789_ABCD, 0, 1, 0)));
      t_rd_en = 1;
      tick;
      t_rd_en = 0;
      check(t_data == part_of(36'h5_6789_ABCD, 1, 1, 0), "R3 (second quarter)",
            36'(t_data), 36'(part_of(36'h5_6789_ABCD, 1, 1, 0)));
      r_data = 18'h0_01FF; r_wr_en = 1;
      tick;
      r_wr_en = 0;
      do_reset(1, 0);
      wide_write(36'h8_1357_9BDF, 1);
      rx_send(36'h2_4680_ACE1, 1);
      tx_on = 1; wr_on = 1;
      drain;  // R11: both lanes restart at piece zero

      finish_run();
   end

endmodule